// File: doc/BRIEF.md
# Floating-Point Coprocessor Command Sequencer

This block is the control unit of a floating-point math coprocessor. It sits beside a host CPU and accepts one operate command at a time. The command is a 32-bit word that names a destination register, two source registers and a 9-bit function field. The 6 low bits of that field pick a function group and an operation within the group. The block drives the source-register indices straight to the host register file. The operand values come back in the same cycle. The block classifies each operand as finite, zero, positive infinity, negative infinity or NaN under IEEE-754 single precision.

For a valid function with no NaN operand, the block runs three external stages in order: argument reduction, the shared iterative core, and result rescaling. Each stage starts on a one-cycle go pulse and ends on a one-cycle done pulse. The group and operation fields steer the reduction and rescaling stages. At the end, the block returns the result and the destination index with a one-cycle valid strobe.

For sine and cosine, the block itself builds the result. It takes the sine and cosine terms from the core and chooses between them, with a possible sign flip, according to the quadrant index that the reduction stage reports. A NaN operand or an unknown function skips every stage and returns a quiet NaN at once.

Top module: `fpcop_sequencer`

## Requirements
- R1: A command is accepted only when all of these hold: `cmd_valid` is high, the block is idle, `cmd_word[31:30]` is `10`, and `cmd_word[24:19]` is `110110` or `110111`. Any other command word is ignored: no go pulse, no result and no busy.
- R2: Fields of the command word:
  - `cmd_word[29:25]` is the destination index. It is returned on `res_reg`.
  - The function field is `cmd_word[13:5]`. Its top bits `[13:11]` must be zero, the group is `[10:8]` and the operation is `[7:5]`.
  - `cmd_word[18:14]` and `cmd_word[4:0]` appear combinationally on `src_a_idx` and `src_b_idx`.
  - The group and operation stay on `stg_grp` and `stg_op` while busy.
- R3: `pre_go` pulses for one cycle, in the cycle after acceptance. `core_go` pulses in the cycle after the clock edge that samples `pre_done`. `post_go` pulses in the cycle after the edge that samples `core_done`. At most one go is high at a time. A done that is high in the same cycle as its own go is ignored.
- R4: `busy` is high from the cycle after acceptance until `res_valid`. `res_valid` is a one-cycle pulse in the cycle after the edge that samples `post_done`, and `busy` is low in that cycle. After reset the block is idle with every strobe low.
- R5: Operand classes on `pre_kind_a` and `pre_kind_b`, held while busy:
  - 1: exponent 0 and mantissa 0 (either sign).
  - 2: exponent 255, mantissa 0, sign 0.
  - 3: exponent 255, mantissa 0, sign 1.
  - 4: exponent 255 and a nonzero mantissa.
  - 0: any other value, including exponent 0 with a nonzero mantissa.
- R6: A NaN `src_a`, or a NaN `src_b` under group 101 (multiply) or group 110 (divide), gives `res_valid` with `res_data` = `32'h7FC00000` in the cycle after acceptance. No go pulse is issued and busy stays low.
- R7: A known function is one of these (group/operation): 000 with operation 0, 1, 2, 4, 5, 6 or 7; 001 with operation 0 or 2; any other group with operation 0; in every case with zero top bits. Any other function is handled exactly as in R6.
- R8: For sine (000/000), `res_data` is chosen by the quadrant `pre_quad` sampled with `pre_done`. Quadrant 0 gives the core sine term, 1 the cosine term, 2 the sine term with its sign bit inverted, and 3 the cosine term with its sign bit inverted. The terms are `core_sin` and `core_cos`, sampled with `core_done`.
- R9: For cosine (000/001), quadrant 0 gives the cosine term, 1 the inverted sine term, 2 the inverted cosine term and 3 the sine term.
- R10: For every other function, `res_data` is `post_data` sampled with `post_done`.
- R11: For a function outside groups 101 and 110, a NaN `src_b` has no effect. The full stage sequence runs.
- R12: A command presented while busy is ignored. The running sequence returns its own destination index, and no extra result or go pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 32 | Operate command |
| src_a_idx | output | 5 | First source index, decoded combinationally |
| src_b_idx | output | 5 | Second source index, decoded combinationally |
| src_a | input | 32 | First operand value |
| src_b | input | 32 | Second operand value |
| busy | output | 1 | Sequence in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_reg | output | 5 | Destination index of the result |
| res_data | output | 32 | Result value |
| stg_grp | output | 3 | Function group for the stages |
| stg_op | output | 3 | Operation within the group |
| stg_a | output | 32 | Latched first operand |
| stg_b | output | 32 | Latched second operand |
| pre_kind_a | output | 3 | Class of the first operand |
| pre_kind_b | output | 3 | Class of the second operand |
| pre_go | output | 1 | Start argument reduction |
| pre_done | input | 1 | Argument reduction finished |
| pre_quad | input | 2 | Quadrant index from reduction |
| core_go | output | 1 | Start the shared core |
| core_done | input | 1 | Core finished |
| core_sin | input | 32 | Core sine term |
| core_cos | input | 32 | Core cosine term |
| post_go | output | 1 | Start result rescaling |
| post_done | input | 1 | Rescaling finished |
| post_data | input | 32 | Rescaled result |

## Verification
The assertions assume the stages behave well. A stage raises its done only while the sequencer waits for it, and only once per go. The sequencer never lets a go overlap another go or the result strobe.

The bench models each stage as a responder. After a go it waits one to three cycles and then gives a single-cycle done, so the stages never produce a stray done. The bench deliberately raises one early done in the same cycle as its go, which is the only case the sequencer is required to filter. Commands are drawn at random over every known function code, with some unknown codes and special operands mixed in. Directed cases cover every quadrant, NaN on each operand, and commands that arrive while the block is busy.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

   typedef enum logic [2:0] {
      K_FIN  = 3'd0,
      K_ZERO = 3'd1,
      K_PINF = 3'd2,
      K_NINF = 3'd3,
      K_NAN  = 3'd4
   } fpkind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE,
      ST_CORE,
      ST_POST
   } seq_state_e;

   localparam logic [1:0] CMD_TAG    = 2'b10;
   localparam logic [4:0] CLASS_STEM = 5'b11011;

   localparam logic [2:0] GRP_TRIG = 3'b000;
   localparam logic [2:0] GRP_ARC  = 3'b001;
   localparam logic [2:0] GRP_MUL  = 3'b101;
   localparam logic [2:0] GRP_DIV  = 3'b110;

endpackage

// File: rtl/mcp_cmd_decode.sv
module mcp_cmd_decode
   import mcp_pkg::*;
#(
   parameter int REG_W = 5,
   parameter int GRP_W = 3,
   parameter int OP_W  = 3,
   parameter int FN_W  = 9,
   parameter int CMD_W = 32
) (
   input  logic [CMD_W-1:0] cmd,
   output logic             fmt_ok,
   output logic             fn_known,
   output logic             trig_fn,
   output logic             cos_fn,
   output logic             uses_b,
   output logic [REG_W-1:0] rd,
   output logic [REG_W-1:0] rs1,
   output logic [REG_W-1:0] rs2,
   output logic [GRP_W-1:0] grp,
   output logic [OP_W-1:0]  op
);

   localparam int CLS_W   = 6;
   localparam int TAG_W   = 2;
   localparam int PAD_W   = FN_W - GRP_W - OP_W;
   localparam int RS2_LSB = 0;
   localparam int OP_LSB  = RS2_LSB + REG_W;
   localparam int GRP_LSB = OP_LSB + OP_W;
   localparam int PAD_LSB = GRP_LSB + GRP_W;
   localparam int RS1_LSB = OP_LSB + FN_W;
   localparam int CLS_LSB = RS1_LSB + REG_W;
   localparam int RD_LSB  = CLS_LSB + CLS_W;
   localparam int TAG_LSB = RD_LSB + REG_W;

   generate
      if (TAG_LSB + TAG_W != CMD_W) begin : g_bad_layout
         $error("command fields do not fill the command word");
      end
      if (GRP_W != 3 || OP_W != 3 || PAD_W < 1) begin : g_bad_fn
         $error("function table is defined for 3-bit group and operation");
      end
   endgenerate

   logic [TAG_W-1:0] tag;
   logic [CLS_W-1:0] cls;
   logic [PAD_W-1:0] pad;

   assign tag = cmd[TAG_LSB +: TAG_W];
   assign cls = cmd[CLS_LSB +: CLS_W];
   assign pad = cmd[PAD_LSB +: PAD_W];
   assign rd  = cmd[RD_LSB  +: REG_W];
   assign rs1 = cmd[RS1_LSB +: REG_W];
   assign rs2 = cmd[RS2_LSB +: REG_W];
   assign grp = cmd[GRP_LSB +: GRP_W];
   assign op  = cmd[OP_LSB  +: OP_W];

   assign fmt_ok = (tag == CMD_TAG) && (cls[CLS_W-1:1] == CLASS_STEM);

   always_comb begin
      fn_known = 1'b0;
      if (pad == '0) begin
         case (grp)
            GRP_TRIG: fn_known = (op != 3'd3);
            GRP_ARC:  fn_known = (op == 3'd0) || (op == 3'd2);
            default:  fn_known = (op == 3'd0);
         endcase
      end
   end

   assign uses_b  = (grp == GRP_MUL) || (grp == GRP_DIV);
   assign trig_fn = (pad == '0) && (grp == GRP_TRIG) && (op[OP_W-1:1] == '0);
   assign cos_fn  = trig_fn && op[0];

endmodule

// File: rtl/mcp_fp_screen.sv
module mcp_fp_screen
   import mcp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] value,
   output fpkind_e               kind
);

   localparam int SIGN_BIT = EXP_W + FRAC_W;

   logic              sgn;
   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] fr;

   assign sgn = value[SIGN_BIT];
   assign ex  = value[FRAC_W +: EXP_W];
   assign fr  = value[FRAC_W-1:0];

   always_comb begin
      if (ex == '1) begin
         if (fr == '0) kind = sgn ? K_NINF : K_PINF;
         else          kind = K_NAN;
      end else if ((ex == '0) && (fr == '0)) begin
         kind = K_ZERO;
      end else begin
         kind = K_FIN;
      end
   end

endmodule

// File: rtl/mcp_quad_sel.sv
module mcp_quad_sel #(
   parameter int DATA_W = 32,
   parameter int QUAD_W = 2
) (
   input  logic [QUAD_W-1:0] quad,
   input  logic              cos_fn,
   input  logic [DATA_W-1:0] sin_term,
   input  logic [DATA_W-1:0] cos_term,
   output logic [DATA_W-1:0] res
);

   generate
      if (QUAD_W != 2) begin : g_bad_quad
         $error("quadrant index must be two bits");
      end
   endgenerate

   // cos(Q) uses the sine row one quadrant ahead
   logic [QUAD_W-1:0] idx;
   logic [DATA_W-1:0] mag;

   assign idx = quad + QUAD_W'(cos_fn);
   assign mag = idx[0] ? cos_term : sin_term;
   assign res = {mag[DATA_W-1] ^ idx[1], mag[DATA_W-2:0]};

endmodule

// File: rtl/fpcop_sequencer.sv
module fpcop_sequencer
   import mcp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int REG_W  = 5,
   parameter int GRP_W  = 3,
   parameter int OP_W   = 3,
   parameter int QUAD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [31:0]       cmd_word,
   output logic [REG_W-1:0]  src_a_idx,
   output logic [REG_W-1:0]  src_b_idx,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              busy,
   output logic              res_valid,
   output logic [REG_W-1:0]  res_reg,
   output logic [DATA_W-1:0] res_data,
   output logic [GRP_W-1:0]  stg_grp,
   output logic [OP_W-1:0]   stg_op,
   output logic [DATA_W-1:0] stg_a,
   output logic [DATA_W-1:0] stg_b,
   output logic [2:0]        pre_kind_a,
   output logic [2:0]        pre_kind_b,
   output logic              pre_go,
   input  logic              pre_done,
   input  logic [QUAD_W-1:0] pre_quad,
   output logic              core_go,
   input  logic              core_done,
   input  logic [DATA_W-1:0] core_sin,
   input  logic [DATA_W-1:0] core_cos,
   output logic              post_go,
   input  logic              post_done,
   input  logic [DATA_W-1:0] post_data
);

   localparam int NUM_OPND = 2;
   localparam int MAG_W    = DATA_W - 1;
   localparam logic [DATA_W-1:0] QNAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   generate
      if (DATA_W != 1 + EXP_W + FRAC_W) begin : g_bad_fmt
         $error("DATA_W must equal sign + exponent + fraction");
      end
   endgenerate

   // decode
   logic             dec_fmt_ok, dec_known, dec_trig, dec_cos, dec_uses_b;
   logic [REG_W-1:0] dec_rd;
   logic [GRP_W-1:0] dec_grp;
   logic [OP_W-1:0]  dec_op;

   mcp_cmd_decode #(
      .REG_W (REG_W),
      .GRP_W (GRP_W),
      .OP_W  (OP_W),
      .FN_W  (9),
      .CMD_W (32)
   ) u_decode (
      .cmd      (cmd_word),
      .fmt_ok   (dec_fmt_ok),
      .fn_known (dec_known),
      .trig_fn  (dec_trig),
      .cos_fn   (dec_cos),
      .uses_b   (dec_uses_b),
      .rd       (dec_rd),
      .rs1      (src_a_idx),
      .rs2      (src_b_idx),
      .grp      (dec_grp),
      .op       (dec_op)
   );

   // operand screening
   logic [DATA_W-1:0] opnd_in [NUM_OPND];
   fpkind_e           kind_in [NUM_OPND];

   assign opnd_in[0] = src_a;
   assign opnd_in[1] = src_b;

   for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_screen
      mcp_fp_screen #(
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) u_screen (
         .value (opnd_in[gi]),
         .kind  (kind_in[gi])
      );
   end

   logic nan_hit;
   logic accept;

   assign nan_hit = (kind_in[0] == K_NAN) || (dec_uses_b && (kind_in[1] == K_NAN));

   // sequencer state and latched command
   seq_state_e        st;
   logic [REG_W-1:0]  rd_q;
   logic [GRP_W-1:0]  grp_q;
   logic [OP_W-1:0]   op_q;
   logic [DATA_W-1:0] a_q, b_q;
   fpkind_e           kind_a_q, kind_b_q;
   logic              trig_q, cos_q;
   logic [QUAD_W-1:0] quad_q;
   logic [DATA_W-1:0] sin_t_q, cos_t_q;
   logic [DATA_W-1:0] trig_res;

   assign accept = cmd_valid && (st == ST_IDLE) && dec_fmt_ok;

   mcp_quad_sel #(
      .DATA_W (DATA_W),
      .QUAD_W (QUAD_W)
   ) u_quad (
      .quad     (quad_q),
      .cos_fn   (cos_q),
      .sin_term (sin_t_q),
      .cos_term (cos_t_q),
      .res      (trig_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         pre_go    <= 1'b0;
         core_go   <= 1'b0;
         post_go   <= 1'b0;
         res_valid <= 1'b0;
         res_reg   <= '0;
         res_data  <= '0;
      end else begin
         pre_go    <= 1'b0;
         core_go   <= 1'b0;
         post_go   <= 1'b0;
         res_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  if (nan_hit || !dec_known) begin
                     res_valid <= 1'b1;
                     res_reg   <= dec_rd;
                     res_data  <= QNAN;
                  end else begin
                     st     <= ST_PRE;
                     pre_go <= 1'b1;
                  end
               end
            end
            ST_PRE: begin
               if (pre_done && !pre_go) begin
                  st      <= ST_CORE;
                  core_go <= 1'b1;
               end
            end
            ST_CORE: begin
               if (core_done && !core_go) begin
                  st      <= ST_POST;
                  post_go <= 1'b1;
               end
            end
            ST_POST: begin
               if (post_done && !post_go) begin
                  st        <= ST_IDLE;
                  res_valid <= 1'b1;
                  res_reg   <= rd_q;
                  res_data  <= trig_q ? trig_res : post_data;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q     <= '0;
         grp_q    <= '0;
         op_q     <= '0;
         a_q      <= '0;
         b_q      <= '0;
         kind_a_q <= K_FIN;
         kind_b_q <= K_FIN;
         trig_q   <= 1'b0;
         cos_q    <= 1'b0;
         quad_q   <= '0;
         sin_t_q  <= '0;
         cos_t_q  <= '0;
      end else begin
         if (accept) begin
            rd_q     <= dec_rd;
            grp_q    <= dec_grp;
            op_q     <= dec_op;
            a_q      <= src_a;
            b_q      <= src_b;
            kind_a_q <= kind_in[0];
            kind_b_q <= kind_in[1];
            trig_q   <= dec_trig;
            cos_q    <= dec_cos;
         end
         if ((st == ST_PRE) && pre_done && !pre_go) begin
            quad_q <= pre_quad;
         end
         if ((st == ST_CORE) && core_done && !core_go) begin
            sin_t_q <= core_sin;
            cos_t_q <= core_cos;
         end
      end
   end

   assign busy       = (st != ST_IDLE);
   assign stg_grp    = grp_q;
   assign stg_op     = op_q;
   assign stg_a      = a_q;
   assign stg_b      = b_q;
   assign pre_kind_a = kind_a_q;
   assign pre_kind_b = kind_b_q;

   // R3
   go_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pre_go, core_go, post_go, res_valid}));

   // R3
   pre_go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_go |=> !pre_go);

   // R4
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R4
   go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_go || core_go || post_go) |-> busy);

   // R6
   fast_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !$past(busy)) |-> (res_data == QNAN));

   // R12
   accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_go |-> !$past(busy));

   // R8
   trig_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(busy) && trig_q) |->
         ((res_data[MAG_W-1:0] == sin_t_q[MAG_W-1:0]) ||
          (res_data[MAG_W-1:0] == cos_t_q[MAG_W-1:0])));

endmodule

// File: tb/fpcop_sequencer_bench.sv
`timescale 1ns/1ps
module fpcop_sequencer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_word = '0;
   logic [4:0]  src_a_idx, src_b_idx;
   logic [31:0] src_a = '0, src_b = '0;
   logic        busy, res_valid;
   logic [4:0]  res_reg;
   logic [31:0] res_data;
   logic [2:0]  stg_grp, stg_op;
   logic [31:0] stg_a, stg_b;
   logic [2:0]  pre_kind_a, pre_kind_b;
   logic        pre_go, core_go, post_go;
   logic        pre_done = 1'b0, core_done = 1'b0, post_done = 1'b0;
   logic [1:0]  pre_quad = '0;
   logic [31:0] core_sin = '0, core_cos = '0, post_data = '0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   localparam logic [31:0] QNAN = 32'h7FC00000;

   always #2 clk = ~clk;

   fpcop_sequencer u_fpcop_sequencer (
      .clk, .rst_n, .cmd_valid, .cmd_word, .src_a_idx, .src_b_idx,
      .src_a, .src_b, .busy, .res_valid, .res_reg, .res_data,
      .stg_grp, .stg_op, .stg_a, .stg_b, .pre_kind_a, .pre_kind_b,
      .pre_go, .pre_done, .pre_quad, .core_go, .core_done, .core_sin,
      .core_cos, .post_go, .post_done, .post_data
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_cmd(input bit cls0, input logic [4:0] rd,
         input logic [4:0] rs1, input logic [2:0] hi, input logic [2:0] g,
         input logic [2:0] o, input logic [4:0] rs2);
      return {2'b10, rd, 5'b11011, cls0, rs1, hi, g, o, rs2};
   endfunction

   function automatic logic [2:0] exp_kind(input logic [31:0] v);
      if (v[30:23] == 8'hFF) return (v[22:0] == 0) ? (v[31] ? 3'd3 : 3'd2) : 3'd4;
      if (v[30:23] == 8'h00 && v[22:0] == 0) return 3'd1;
      return 3'd0;
   endfunction

   function automatic bit exp_known(input logic [2:0] hi, input logic [2:0] g,
                                    input logic [2:0] o);
      if (hi != 0) return 1'b0;
      case (g)
         3'b000:  return o != 3'd3;
         3'b001:  return (o == 3'd0) || (o == 3'd2);
         default: return o == 3'd0;
      endcase
   endfunction

   function automatic logic [31:0] exp_quad(input logic [1:0] q, input bit is_cos,
                                            input logic [31:0] s, input logic [31:0] c);
      logic [1:0] k;
      k = q + {1'b0, is_cos};
      case (k)
         2'd0:    return s;
         2'd1:    return c;
         2'd2:    return s ^ 32'h80000000;
         default: return c ^ 32'h80000000;
      endcase
   endfunction

   function automatic logic [31:0] rand_fp();
      int r;
      r = $urandom % 12;
      case (r)
         0: return ($urandom % 2) ? 32'h80000000 : 32'h00000000;
         1: return 32'h7F800000;
         2: return 32'hFF800000;
         3: return {($urandom % 2) == 1, 8'hFF, 23'(1 + ($urandom % 23'h7FFFFE))};
         default: return {($urandom % 2) == 1, 8'($urandom % 255), 23'($urandom)};
      endcase
   endfunction

   task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_word = w; src_a = a; src_b = b;
      @(negedge clk);
      cmd_valid = 1'b0; src_a = $urandom; src_b = $urandom;
   endtask

   task automatic wait_quiet(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(!pre_go && !core_go && !post_go, "R3", "go during wait",
             {29'd0, pre_go, core_go, post_go}, 32'd0);
      end
   endtask

   task automatic run_cmd(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] q, input bit early, input bit inject);
      logic [2:0]  g, o, hi;
      logic [4:0]  rd;
      logic [31:0] s, c, p, expv;
      bit fast, binop;
      g = w[10:8]; o = w[7:5]; hi = w[13:11]; rd = w[29:25];
      s = $urandom; c = $urandom; p = $urandom;
      binop = (g == 3'b101) || (g == 3'b110);
      fast = (exp_kind(a) == 3'd4) || (binop && exp_kind(b) == 3'd4) || !exp_known(hi, g, o);
      issue(w, a, b);
      if (fast) begin
         chk(res_valid, exp_known(hi, g, o) ? "R6" : "R7", "fast strobe", {31'd0, res_valid}, 1);
         chk(res_data == QNAN, exp_known(hi, g, o) ? "R6" : "R7", "fast data", res_data, QNAN);
         chk(res_reg == rd, "R2", "fast rd", {27'd0, res_reg}, {27'd0, rd});
         chk(!busy && !pre_go, "R6", "fast no seq", {30'd0, busy, pre_go}, 0);
         @(negedge clk);
         chk(!res_valid && !busy && !pre_go, "R4", "fast after", {29'd0, res_valid, busy, pre_go}, 0);
         return;
      end
      chk(busy, "R4", "busy after accept", {31'd0, busy}, 1);
      chk(pre_go, "R3", "pre_go", {31'd0, pre_go}, 1);
      chk(stg_grp == g && stg_op == o, "R2", "grp/op", {26'd0, stg_grp, stg_op}, {26'd0, g, o});
      chk(pre_kind_a == exp_kind(a), "R5", "kind a", {29'd0, pre_kind_a}, {29'd0, exp_kind(a)});
      chk(pre_kind_b == exp_kind(b), binop ? "R5" : "R11", "kind b", {29'd0, pre_kind_b}, {29'd0, exp_kind(b)});
      chk(stg_a == a, "R2", "stg_a", stg_a, a);
      if (early) begin
         pre_done = 1'b1; pre_quad = ~q;
         @(negedge clk);
         pre_done = 1'b0;
         chk(!core_go, "R3", "early done ignored", {31'd0, core_go}, 0);
      end
      wait_quiet(1 + $urandom % 3);
      pre_done = 1'b1; pre_quad = q;
      @(negedge clk);
      pre_done = 1'b0;
      chk(core_go, "R3", "core_go", {31'd0, core_go}, 1);
      if (inject) begin
         @(negedge clk);
         cmd_valid = 1'b1;
         cmd_word = mk_cmd(1'b0, rd ^ 5'h1F, 5'd2, 3'd0, 3'b100, 3'd0, 5'd3);
         src_a = 32'h3F800000;
         @(negedge clk);
         cmd_valid = 1'b0;
         chk(!pre_go && busy, "R12", "cmd while busy", {30'd0, pre_go, busy}, 32'd1);
      end
      wait_quiet(1 + $urandom % 3);
      core_done = 1'b1; core_sin = s; core_cos = c;
      @(negedge clk);
      core_done = 1'b0;
      chk(post_go, "R3", "post_go", {31'd0, post_go}, 1);
      wait_quiet(1 + $urandom % 3);
      post_done = 1'b1; post_data = p;
      @(negedge clk);
      post_done = 1'b0;
      chk(res_valid && !busy, "R4", "result strobe", {30'd0, res_valid, busy}, 32'd2);
      chk(res_reg == rd, inject ? "R12" : "R2", "res_reg", {27'd0, res_reg}, {27'd0, rd});
      if (g == 3'b000 && o == 3'd0) begin
         expv = exp_quad(q, 1'b0, s, c);
         chk(res_data == expv, "R8", "sin quadrant", res_data, expv);
      end else if (g == 3'b000 && o == 3'd1) begin
         expv = exp_quad(q, 1'b1, s, c);
         chk(res_data == expv, "R9", "cos quadrant", res_data, expv);
      end else begin
         chk(res_data == p, "R10", "post data", res_data, p);
      end
      @(negedge clk);
      chk(!res_valid && !busy && !pre_go, inject ? "R12" : "R4", "after result",
          {29'd0, res_valid, busy, pre_go}, 0);
   endtask

   task automatic run_ignored(input logic [31:0] w);
      issue(w, 32'h3F800000, 32'h40000000);
      chk(!busy && !res_valid && !pre_go, "R1", "ignored cmd", {29'd0, busy, res_valid, pre_go}, 0);
      @(negedge clk);
      chk(!busy && !res_valid && !pre_go, "R1", "ignored cmd later", {29'd0, busy, res_valid, pre_go}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R4 watchdog act=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [2:0] g, o, hi;
      logic [31:0] w;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      chk(!busy && !res_valid && !pre_go && !core_go && !post_go, "R4", "reset state",
          {27'd0, busy, res_valid, pre_go, core_go, post_go}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 source indices
      cmd_word = mk_cmd(1'b0, 5'd1, 5'd17, 3'd0, 3'd0, 3'd0, 5'd9);
      #0.1;
      chk(src_a_idx == 5'd17 && src_b_idx == 5'd9, "R2", "src idx",
          {22'd0, src_a_idx, src_b_idx}, {22'd0, 5'd17, 5'd9});

      // R1 bad format
      run_ignored({2'b11, 5'd4, 6'b110110, 5'd1, 9'd0, 5'd2});
      run_ignored({2'b10, 5'd4, 6'b110101, 5'd1, 9'd0, 5'd2});

      // R8 / R9 every quadrant
      for (int q = 0; q < 4; q++) begin
         run_cmd(mk_cmd(1'b0, 5'd5, 5'd1, 3'd0, 3'd0, 3'd0, 5'd2), 32'h3F800000, 32'h0, 2'(q), 0, 0);
         run_cmd(mk_cmd(1'b1, 5'd6, 5'd1, 3'd0, 3'd0, 3'd1, 5'd2), 32'h3F000000, 32'h0, 2'(q), 0, 0);
      end

      // R5 denormal and negative zero, R3 early done
      run_cmd(mk_cmd(1'b0, 5'd7, 5'd1, 3'd0, 3'b101, 3'd0, 5'd2), 32'h00000001, 32'h80000000, 2'd0, 1, 0);
      // R11 NaN second operand of unary function
      run_cmd(mk_cmd(1'b0, 5'd8, 5'd1, 3'd0, 3'b100, 3'd0, 5'd2), 32'h40800000, 32'h7FC00001, 2'd1, 0, 0);
      // R6 NaN second operand of divide
      run_cmd(mk_cmd(1'b0, 5'd9, 5'd1, 3'd0, 3'b110, 3'd0, 5'd2), 32'h40800000, 32'hFF800001, 2'd0, 0, 0);
      // R6 NaN first operand
      run_cmd(mk_cmd(1'b1, 5'd10, 5'd1, 3'd0, 3'b111, 3'd0, 5'd2), 32'h7F800100, 32'h0, 2'd0, 0, 0);
      // R7 unknown codes
      run_cmd(mk_cmd(1'b0, 5'd11, 5'd1, 3'd0, 3'b000, 3'd3, 5'd2), 32'h3F800000, 32'h0, 2'd0, 0, 0);
      run_cmd(mk_cmd(1'b0, 5'd12, 5'd1, 3'd0, 3'b001, 3'd1, 5'd2), 32'h3F800000, 32'h0, 2'd0, 0, 0);
      run_cmd(mk_cmd(1'b0, 5'd13, 5'd1, 3'd4, 3'b000, 3'd0, 5'd2), 32'h3F800000, 32'h0, 2'd0, 0, 0);
      // R12 command while busy
      run_cmd(mk_cmd(1'b0, 5'd14, 5'd1, 3'd0, 3'b010, 3'd0, 5'd2), 32'h3F800000, 32'h0, 2'd2, 0, 1);

      // random mix
      for (int n = 0; n < 60; n++) begin
         hi = 3'd0;
         case ($urandom % 16)
            0:  begin g = 3'd0; o = 3'd0; end
            1:  begin g = 3'd0; o = 3'd1; end
            2:  begin g = 3'd0; o = 3'd2; end
            3:  begin g = 3'd0; o = 3'd4; end
            4:  begin g = 3'd0; o = 3'd5; end
            5:  begin g = 3'd0; o = 3'd6; end
            6:  begin g = 3'd0; o = 3'd7; end
            7:  begin g = 3'd1; o = 3'd0; end
            8:  begin g = 3'd1; o = 3'd2; end
            9:  begin g = 3'd2; o = 3'd0; end
            10: begin g = 3'd3; o = 3'd0; end
            11: begin g = 3'd4; o = 3'd0; end
            12: begin g = 3'd5; o = 3'd0; end
            13: begin g = 3'd6; o = 3'd0; end
            14: begin g = 3'd7; o = 3'd0; end
            default: begin g = 3'($urandom); o = 3'($urandom | 1); hi = 3'($urandom); end
         endcase
         w = mk_cmd(1'($urandom), 5'($urandom), 5'($urandom), hi, g, o, 5'($urandom));
         run_cmd(w, rand_fp(), rand_fp(), 2'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule